// File: doc/BRIEF.md
# Access Width Splitter and Packer

This block sits between a byte-addressed internal request port and an external bus cycle generator. It takes one internal access of 8, 16 or 32 bits and breaks it into as many narrow external sub-cycles as the configured external data width needs: one or two on a 16-bit bus, and one, two or four on an 8-bit bus. Each sub-cycle is handed to the cycle generator through a simple request/done handshake. The generator produces the strobe timing inside each cycle; this block does not.

For every sub-cycle the block works out the external address (the byte address shifted right by one on a 16-bit bus), picks the write data lane, and states whether the upper byte lane is driven. Pieces go out in ascending address order, least significant piece first. On reads the returned pieces are packed into one 32-bit word, and a single acknowledge is given after the last sub-cycle finishes. The block drives the active-low chip select of the addressed bank. Between the sub-cycles of a split write the chip select stays low. Between the sub-cycles of a split read it is released. A per-bank write-protect mask blocks writes: no sub-cycle is issued and an error response is returned.

Top module: `xwa_top`

## Requirements
- R1: With `bus16`=1, a word access (`req_size`=2 or 3) produces two external sub-cycles, and a halfword (`req_size`=1) or byte (`req_size`=0) access produces one.
- R2: With `bus16`=0, a byte access produces one sub-cycle, a halfword two and a word four.
- R3: Sub-cycles are issued in ascending address order, lowest piece first. Write data for sub-cycle k is bits [16k+15:16k] of `req_wdata` on a 16-bit bus, and bits [8k+7:8k] placed in `cyc_wdata[7:0]` on an 8-bit bus.
- R4: `cyc_addr` for sub-cycle k is (byte address + 2k) >> 1 when `bus16`=1, and byte address + k when `bus16`=0.
- R5: `cyc_hi_en` is 1 only for halfword and word accesses on a 16-bit bus. When it is 0, `cyc_wdata[15:8]` is 0, and a byte access on a 16-bit bus carries its byte in `cyc_wdata[7:0]`.
- R6: Between two sub-cycles of one write, the selected bank's chip select stays low.
- R7: Between two sub-cycles of one read, every chip select is high for at least one cycle.
- R8: Read pieces are packed little-endian into `rsp_rdata`: piece k of an 8-bit bus fills byte k; piece k of a 16-bit bus fills halfword k. A byte read on a 16-bit bus returns `cyc_rdata[7:0]`. All unfilled bits are 0.
- R9: A write whose bank bit in `wp_mask` is set issues no sub-cycle and answers with `rsp_err`=1. Reads of that bank proceed normally with `rsp_err`=0.
- R10: `rsp_valid` is a one-cycle pulse, raised only after the last sub-cycle's `cyc_done`. `req_ready` is high only while no access is in progress.
- R11: After reset `req_ready`=1, `cyc_req`=0, `rsp_valid`=0 and all of `cyc_cs_n` are high. While idle, all chip selects stay high.
- R12: `cyc_req` stays high until `cyc_done`. While it is high, exactly one chip select is low: the one indexed by the top address bits `req_addr[AW-1:AW-log2(NBANK)]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus16 | input | 1 | External data width: 1 = 16-bit, 0 = 8-bit |
| wp_mask | input | NBANK | Per-bank write protect |
| req_valid | input | 1 | Internal access request |
| req_ready | output | 1 | Block idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_addr | input | AW | Byte address, bank in top bits |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Write to protected bank |
| rsp_rdata | output | 32 | Packed read data |
| cyc_req | output | 1 | Sub-cycle request to cycle generator |
| cyc_write | output | 1 | Sub-cycle direction |
| cyc_addr | output | AW | External address of the sub-cycle |
| cyc_wdata | output | 16 | Sub-cycle write data |
| cyc_hi_en | output | 1 | Upper byte lane driven |
| cyc_cs_n | output | NBANK | Active-low bank chip selects |
| cyc_done | input | 1 | Sub-cycle finished (one-cycle pulse) |
| cyc_rdata | input | 16 | Sub-cycle read data, valid with cyc_done |

## Verification
The assertions take several things for granted about the environment:
- accesses are naturally aligned to their size;
- `bus16` and `wp_mask` do not change while an access is in flight;
- `cyc_done` pulses at most once per sub-cycle, and only while `cyc_req` is high.

The stimulus stays within these limits. It uses only aligned addresses and changes width or protection only between responses. Its cycle-generator model raises `cyc_done` for a single cycle after a chosen latency, and it lowers `cyc_done` once `cyc_req` drops.

// File: rtl/xwa_pkg.sv
package xwa_pkg;
  localparam int DW = 32;
  localparam int EW = 16;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_GAP   = 2'd2,
    ST_RESP  = 2'd3
  } state_e;
endpackage

// File: rtl/xwa_piece_plan.sv
// Per-piece plan: number of pieces, external address, upper lane use.
module xwa_piece_plan
  import xwa_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [1:0]    size,
  input  logic          wide,
  input  logic [AW-1:0] base,
  input  logic [1:0]    idx,
  output logic [1:0]    last,
  output logic [AW-1:0] ext_addr,
  output logic          hi_en
);
  logic [AW-1:0] byte_addr;

  always_comb begin
    case (size_e'(size))
      SZ_BYTE: last = 2'd0;
      SZ_HALF: last = wide ? 2'd0 : 2'd1;
      default: last = wide ? 2'd1 : 2'd3;
    endcase
    byte_addr = base + (wide ? AW'({idx, 1'b0}) : AW'(idx));
    ext_addr  = wide ? (byte_addr >> 1) : byte_addr;
    hi_en     = wide && (size_e'(size) != SZ_BYTE);
  end
endmodule

// File: rtl/xwa_lane_sel.sv
// Selects the write data lane for the current piece.
module xwa_lane_sel
  import xwa_pkg::*;
(
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    idx,
  input  logic          wide,
  input  logic          hi_en,
  output logic [EW-1:0] lane
);
  logic [DW-1:0] shifted;

  always_comb begin
    if (wide) shifted = wdata >> {idx, 4'b0000};
    else      shifted = wdata >> {idx, 3'b000};
    lane = hi_en ? shifted[EW-1:0] : {8'h00, shifted[7:0]};
  end
endmodule

// File: rtl/xwa_rd_pack.sv
// Packs returned read pieces into one word, one byte slot per generate lane.
module xwa_rd_pack
  import xwa_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          cap,
  input  logic [1:0]    idx,
  input  logic          wide,
  input  logic          hi_en,
  input  logic [EW-1:0] piece,
  output logic [DW-1:0] word
);
  localparam int NB = DW / 8;

  for (genvar j = 0; j < NB; j++) begin : g_slot
    logic       hit;
    logic [7:0] src;
    logic [7:0] slot_q;

    always_comb begin
      if (wide) begin
        hit = hi_en ? (idx == 2'(j / 2)) : (j == 0);
        src = piece[8*(j%2) +: 8];
      end else begin
        hit = (idx == 2'(j));
        src = piece[7:0];
      end
    end

    always_ff @(posedge clk) begin
      if (rst || clr)      slot_q <= 8'h00;
      else if (cap && hit) slot_q <= src;
    end

    assign word[8*j +: 8] = slot_q;
  end
endmodule

// File: rtl/xwa_top.sv
// Splits internal accesses into narrow external sub-cycles and packs reads.
module xwa_top
  import xwa_pkg::*;
#(
  parameter int AW    = 16,
  parameter int NBANK = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus16,
  input  logic [NBANK-1:0] wp_mask,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [DW-1:0]    rsp_rdata,
  output logic             cyc_req,
  output logic             cyc_write,
  output logic [AW-1:0]    cyc_addr,
  output logic [EW-1:0]    cyc_wdata,
  output logic             cyc_hi_en,
  output logic [NBANK-1:0] cyc_cs_n,
  input  logic             cyc_done,
  input  logic [EW-1:0]    cyc_rdata
);
  localparam int BW = $clog2(NBANK);

  state_e           st;
  logic             wr_q, w16_q, req_q, rspv_q, err_q;
  logic [1:0]       size_q, idx_q, last_idx;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [BW-1:0]    bank_q, bank_in;
  logic [NBANK-1:0] csn_q;

  function automatic logic [NBANK-1:0] cs_pattern(input logic [BW-1:0] b);
    return ~(NBANK'(1) << b);
  endfunction

  assign bank_in = req_addr[AW-1 -: BW];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      req_q   <= 1'b0;
      csn_q   <= '1;
      rspv_q  <= 1'b0;
      err_q   <= 1'b0;
      idx_q   <= 2'd0;
      wr_q    <= 1'b0;
      w16_q   <= 1'b0;
      size_q  <= 2'd0;
      addr_q  <= '0;
      wdata_q <= '0;
      bank_q  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          wr_q    <= req_write;
          w16_q   <= bus16;
          size_q  <= req_size;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          bank_q  <= bank_in;
          idx_q   <= 2'd0;
          if (req_write && wp_mask[bank_in]) begin
            st     <= ST_RESP;
            rspv_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            st    <= ST_ISSUE;
            req_q <= 1'b1;
            csn_q <= cs_pattern(bank_in);
          end
        end
        ST_ISSUE: if (cyc_done) begin
          req_q <= 1'b0;
          if (idx_q == last_idx) begin
            st     <= ST_RESP;
            rspv_q <= 1'b1;
            csn_q  <= '1;
          end else begin
            st    <= ST_GAP;
            idx_q <= idx_q + 2'd1;
            if (!wr_q) csn_q <= '1;
          end
        end
        ST_GAP: begin
          st    <= ST_ISSUE;
          req_q <= 1'b1;
          csn_q <= cs_pattern(bank_q);
        end
        default: begin
          st     <= ST_IDLE;
          rspv_q <= 1'b0;
          err_q  <= 1'b0;
        end
      endcase
    end
  end

  xwa_piece_plan #(.AW(AW)) plan_i (
    .size(size_q), .wide(w16_q), .base(addr_q), .idx(idx_q),
    .last(last_idx), .ext_addr(cyc_addr), .hi_en(cyc_hi_en)
  );

  xwa_lane_sel lane_i (
    .wdata(wdata_q), .idx(idx_q), .wide(w16_q), .hi_en(cyc_hi_en),
    .lane(cyc_wdata)
  );

  xwa_rd_pack pack_i (
    .clk(clk), .rst(rst),
    .clr((st == ST_IDLE) && req_valid),
    .cap((st == ST_ISSUE) && cyc_done && !wr_q),
    .idx(idx_q), .wide(w16_q), .hi_en(cyc_hi_en),
    .piece(cyc_rdata), .word(rsp_rdata)
  );

  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = rspv_q;
  assign rsp_err   = err_q;
  assign cyc_req   = req_q;
  assign cyc_write = wr_q;
  assign cyc_cs_n  = csn_q;
endmodule

// File: rtl/xwa_checker.sv
module xwa_checker #(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             bus16,
  input logic [NBANK-1:0] wp_mask,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             cyc_req,
  input logic             cyc_write,
  input logic             cyc_hi_en,
  input logic [NBANK-1:0] cyc_cs_n,
  input logic             cyc_done
);
  a_r12_hold_until_done: assert property (@(posedge clk) disable iff (rst)
    cyc_req && !cyc_done |=> cyc_req);

  a_r12_single_cs: assert property (@(posedge clk) disable iff (rst)
    cyc_req |-> $countones(~cyc_cs_n) == 1);

  a_r6_write_gap_cs: assert property (@(posedge clk) disable iff (rst)
    $fell(cyc_req) && !rsp_valid && cyc_write |-> !(&cyc_cs_n));

  a_r7_read_gap_cs: assert property (@(posedge clk) disable iff (rst)
    $fell(cyc_req) && !rsp_valid && !cyc_write |-> (&cyc_cs_n));

  a_r9_no_protected_write: assert property (@(posedge clk) disable iff (rst)
    cyc_req && cyc_write |-> ((~cyc_cs_n) & wp_mask) == '0);

  a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r10_rsp_after_last: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !cyc_req && (&cyc_cs_n));

  a_r10_ready_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !cyc_req);

  a_r5_narrow_no_hi: assert property (@(posedge clk) disable iff (rst)
    cyc_req && !bus16 |-> !cyc_hi_en);
endmodule

bind xwa_top xwa_checker #(.NBANK(NBANK)) chk_i (
  .clk(clk), .rst(rst), .bus16(bus16), .wp_mask(wp_mask),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .cyc_req(cyc_req),
  .cyc_write(cyc_write), .cyc_hi_en(cyc_hi_en), .cyc_cs_n(cyc_cs_n),
  .cyc_done(cyc_done)
);

// File: tb/xwa_top_tb_top.sv
module xwa_top_tb_top;
  localparam int AW = 16;
  localparam int NBANK = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic             bus16 = 1'b1;
  logic [NBANK-1:0] wp_mask = '0;
  logic             req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]       req_size = 2'd0;
  logic [AW-1:0]    req_addr = '0;
  logic [31:0]      req_wdata = '0;
  logic             req_ready, rsp_valid, rsp_err;
  logic [31:0]      rsp_rdata;
  logic             cyc_req, cyc_write, cyc_hi_en;
  logic [AW-1:0]    cyc_addr;
  logic [15:0]      cyc_wdata;
  logic [NBANK-1:0] cyc_cs_n;
  logic             cyc_done = 1'b0;
  logic [15:0]      cyc_rdata = '0;

  xwa_top #(.AW(AW), .NBANK(NBANK)) dut_i (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  logic [AW-1:0] q_addr[$];
  logic [15:0]   q_wd[$];
  bit            q_hi[$];
  bit            exp_wr;
  logic [NBANK-1:0] exp_csn = '1;
  int sub_seen = 0, lat = 0, cnt = 0;
  bit prev_req = 0;

  function automatic logic [15:0] gen_data(logic [AW-1:0] a);
    return {a[7:0] ^ 8'hA5, a[7:0] + 8'h3C};
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Cycle-generator model and per-clock comparison against the reference queues.
  always @(negedge clk) begin
    if (rst) begin
      cyc_done = 1'b0;
      cnt = 0;
      prev_req = 0;
    end else begin
      if (cyc_req) begin
        cyc_done  = (cnt >= lat);
        cyc_rdata = gen_data(cyc_addr);
        cnt++;
      end else begin
        cyc_done = 1'b0;
        cnt = 0;
      end
      if (cyc_req && !prev_req) begin
        sub_seen++;
        if (q_addr.size() == 0) begin
          chk(0, "R9", "unexpected sub-cycle", 32'(cyc_addr), 0);
        end else begin
          logic [AW-1:0] ea;
          logic [15:0] wd;
          bit hi;
          ea = q_addr.pop_front();
          wd = q_wd.pop_front();
          hi = q_hi.pop_front();
          chk(cyc_addr == ea, "R4", "sub-cycle address", 32'(cyc_addr), 32'(ea));
          chk(cyc_write == exp_wr, "R3", "sub-cycle direction", 32'(cyc_write), 32'(exp_wr));
          chk(cyc_hi_en == hi, "R5", "upper lane enable", 32'(cyc_hi_en), 32'(hi));
          if (exp_wr)
            chk(cyc_wdata == wd, "R3", "sub-cycle write data", 32'(cyc_wdata), 32'(wd));
        end
      end
      if (cyc_req)
        chk(cyc_cs_n == exp_csn, "R12", "chip select during sub-cycle", 32'(cyc_cs_n), 32'(exp_csn));
      if (prev_req && !cyc_req && !rsp_valid) begin
        if (exp_wr)
          chk(cyc_cs_n == exp_csn, "R6", "cs held between write pieces", 32'(cyc_cs_n), 32'(exp_csn));
        else
          chk(cyc_cs_n == '1, "R7", "cs released between read pieces", 32'(cyc_cs_n), 32'hF);
      end
      if (req_ready)
        chk(cyc_cs_n == '1 && !cyc_req, "R11", "idle chip selects", 32'(cyc_cs_n), 32'hF);
      prev_req = cyc_req;
    end
  end

  task automatic access(bit w16, bit wr, logic [1:0] sz, logic [AW-1:0] a,
                        logic [31:0] wd, bit prot, int l, string tag);
    int n, step;
    logic [31:0] exp_rd;
    int g;
    n = w16 ? ((sz >= 2) ? 2 : 1) : (1 << ((sz == 3) ? 2 : sz));
    step = w16 ? 2 : 1;
    exp_rd = '0;
    for (int k = 0; k < n; k++) begin
      logic [AW-1:0] ba, ea;
      logic [15:0] d;
      ba = a + AW'(k * step);
      ea = w16 ? (ba >> 1) : ba;
      d = gen_data(ea);
      if (!prot) begin
        q_addr.push_back(ea);
        q_hi.push_back(w16 && sz != 0);
        if (w16) q_wd.push_back((sz == 0) ? {8'h00, wd[7:0]} : 16'(wd >> (16 * k)));
        else     q_wd.push_back({8'h00, 8'(wd >> (8 * k))});
      end
      if (w16) exp_rd = (sz == 0) ? {24'h0, d[7:0]} : (exp_rd | (32'(d) << (16 * k)));
      else     exp_rd = exp_rd | (32'(d[7:0]) << (8 * k));
    end
    exp_wr = wr;
    exp_csn = ~(NBANK'(1) << a[AW-1 -: 2]);
    lat = l;
    sub_seen = 0;
    @(negedge clk);
    chk(req_ready, "R10", "ready before request", 32'(req_ready), 1);
    bus16 = w16; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    g = 0;
    while (!rsp_valid && g < 200) begin
      @(negedge clk);
      g++;
    end
    chk(rsp_valid, "R10", "response arrived", 32'(rsp_valid), 1);
    chk(sub_seen == (prot ? 0 : n), tag, "sub-cycle count", 32'(sub_seen), 32'(prot ? 0 : n));
    chk(q_addr.size() == 0, "R10", "ack only after last piece", 32'(q_addr.size()), 0);
    chk(rsp_err == prot, "R9", "error response", 32'(rsp_err), 32'(prot));
    if (!wr)
      chk(rsp_rdata == exp_rd, "R8", "packed read data", rsp_rdata, exp_rd);
    @(negedge clk);
    chk(!rsp_valid, "R10", "single-cycle response", 32'(rsp_valid), 0);
    q_addr.delete(); q_wd.delete(); q_hi.delete();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "reset ready", 32'(req_ready), 1);
    chk(cyc_req == 1'b0, "R11", "reset cyc_req", 32'(cyc_req), 0);
    chk(rsp_valid == 1'b0, "R11", "reset rsp_valid", 32'(rsp_valid), 0);
    chk(cyc_cs_n == '1, "R11", "reset chip selects", 32'(cyc_cs_n), 32'hF);

    // 16-bit external bus
    access(1, 1, 2'd2, 16'h0104, 32'hDEADBEEF, 0, 0, "R1");
    access(1, 0, 2'd2, 16'h4208, 32'h0,        0, 2, "R1");
    access(1, 1, 2'd1, 16'h0012, 32'h0000CAFE, 0, 1, "R1");
    access(1, 0, 2'd1, 16'h8036, 32'h0,        0, 0, "R1");
    access(1, 1, 2'd0, 16'h0011, 32'h00000077, 0, 0, "R5");
    access(1, 0, 2'd0, 16'hC023, 32'h0,        0, 1, "R5");
    access(1, 0, 2'd3, 16'h4010, 32'h0,        0, 0, "R1");
    // 8-bit external bus
    access(0, 1, 2'd0, 16'h0005, 32'h000000A1, 0, 0, "R2");
    access(0, 0, 2'd0, 16'h4007, 32'h0,        0, 1, "R2");
    access(0, 1, 2'd1, 16'h8044, 32'h00001234, 0, 0, "R2");
    access(0, 0, 2'd1, 16'hC04A, 32'h0,        0, 2, "R2");
    access(0, 1, 2'd2, 16'h0120, 32'h89ABCDEF, 0, 1, "R2");
    access(0, 0, 2'd2, 16'h4130, 32'h0,        0, 0, "R2");
    // write protection on bank 2
    wp_mask = 4'b0100;
    access(1, 1, 2'd2, 16'h8040, 32'h11223344, 1, 0, "R9");
    access(0, 1, 2'd0, 16'h8003, 32'h00000055, 1, 0, "R9");
    access(1, 0, 2'd2, 16'h8040, 32'h0,        0, 1, "R9");
    access(0, 1, 2'd1, 16'h0060, 32'h00005A5A, 0, 0, "R9");
    wp_mask = '0;
    repeat (2) @(negedge clk);
    summary();
  end
endmodule